// File: doc/BRIEF.md
# Multichannel Threshold Spike Event Detector

This block watches a time-multiplexed stream of signed 10-bit samples. Each sample carries the index of the recording channel it belongs to, and channels may be sampled at different rates. Every channel has its own upper threshold, lower threshold and enable bit. When an enabled channel produces a sample above its upper threshold or below its lower threshold, the block captures a fixed 16-sample window for that channel: the 4 samples before the crossing, the crossing sample itself, and the next 11 samples of the same channel. It then emits the window as one event packet.

Samples that cause no crossing produce no output. The downstream link therefore carries spike snippets only, never raw data. Each channel keeps a small history ring, so the samples before the crossing are already at hand when the trigger arrives. Finished windows wait in a short event queue. The queue drains through a valid/ready port that accepts back-pressure.

Top module: `spike_event_detector`

## Requirements
- R1: Samples are two's-complement signed `SAMPLE_W`-bit values. A sample is accepted on a cycle where `in_valid` is 1, and belongs to channel `in_ch`.
- R2: A cycle with `cfg_we` = 1 writes the upper threshold, the lower threshold and the enable bit of channel `cfg_ch`. The upper threshold must be greater than the lower one. After reset, every channel is disabled.
- R3: An enabled channel that is not capturing triggers when a sample is strictly greater than its upper threshold (polarity 1) or strictly less than its lower threshold (polarity 0). A sample equal to a threshold does not trigger.
- R4: The window holds, in this order: the 4 samples of that channel that came before the trigger (oldest first, with 0 for any slot not yet filled since reset), the trigger sample, and the next 11 samples of that channel.
- R5: While a channel is capturing, further crossings on that channel do not start a new window. They are recorded only as window samples.
- R6: A disabled channel never triggers, but its samples still enter its history.
- R7: A packet is one header word followed by 16 sample words. On the header word `out_first` = 1, bits [CH_W-1:0] hold the channel and bit 9 holds the polarity. `out_last` = 1 on the 16th sample word.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data`, `out_first` and `out_last` keep their values.
- R9: Finished windows enter a queue of `EVQ_DEPTH` events. A window that finishes while the queue is full, and is not being popped in that cycle, is dropped. A drop sets `ovf`, and `ovf` stays at 1 until reset.
- R10: Channels are captured independently, so windows on different channels may overlap in time. A packet is offered on the cycle after its last sample is accepted.
- R11: Reset clears all histories, capture states, queued events and `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_ch | input | CH_W | Channel index of the sample |
| in_sample | input | SAMPLE_W | Signed sample value |
| cfg_we | input | 1 | Write the configuration of one channel |
| cfg_ch | input | CH_W | Channel being configured |
| cfg_pos | input | SAMPLE_W | Signed upper threshold |
| cfg_neg | input | SAMPLE_W | Signed lower threshold |
| cfg_en | input | 1 | Channel enable |
| out_valid | output | 1 | Packet word available |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | SAMPLE_W | Header or sample word |
| out_first | output | 1 | Current word is the header |
| out_last | output | 1 | Current word is the final sample |
| ovf | output | 1 | Sticky flag: an event was dropped |

## Verification
The bench builds the detector with 8 channels and a queue depth of 2, leaving the other parameters at their defaults. With only 8 channels, every channel can be made to trigger, stay disabled or fill its window within a few hundred cycles. A queue depth of 2 means three windows finishing under a stalled sink are enough to force a drop. A scoreboard built from the requirements predicts every packet word, including the zero-filled history after reset, so the ordering of the window and the refractory behaviour are checked word by word.

// File: rtl/spk_pkg.sv
package spk_pkg;
   typedef enum logic {
      POL_NEG = 1'b0,
      POL_POS = 1'b1
   } spk_pol_e;
endpackage

// File: rtl/spk_thresh_cfg.sv
module spk_thresh_cfg
   import spk_pkg::*;
#(
   parameter int NUM_CH    = 64,
   parameter int SAMPLE_W  = 10,
   parameter bit INCLUSIVE = 1'b0,
   localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CH_W-1:0]     cfg_ch,
   input  logic [SAMPLE_W-1:0] cfg_pos,
   input  logic [SAMPLE_W-1:0] cfg_neg,
   input  logic                cfg_en,
   input  logic [CH_W-1:0]     in_ch,
   input  logic [SAMPLE_W-1:0] in_sample,
   output logic                hit,
   output spk_pol_e            hit_pol
);
   localparam logic [SAMPLE_W-1:0] SMAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic [SAMPLE_W-1:0] SMIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

   logic [SAMPLE_W-1:0] pos_r [NUM_CH];
   logic [SAMPLE_W-1:0] neg_r [NUM_CH];
   logic [NUM_CH-1:0]   en_r;
   logic                pos_x, neg_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NUM_CH; c++) begin
            pos_r[c] <= SMAX;
            neg_r[c] <= SMIN;
         end
         en_r <= '0;
      end else if (cfg_we) begin
         pos_r[cfg_ch] <= cfg_pos;
         neg_r[cfg_ch] <= cfg_neg;
         en_r[cfg_ch]  <= cfg_en;
      end
   end

   generate
      if (INCLUSIVE) begin : g_incl
         assign pos_x = $signed(in_sample) >= $signed(pos_r[in_ch]);
         assign neg_x = $signed(in_sample) <= $signed(neg_r[in_ch]);
      end else begin : g_strict
         assign pos_x = $signed(in_sample) > $signed(pos_r[in_ch]);
         assign neg_x = $signed(in_sample) < $signed(neg_r[in_ch]);
      end
   endgenerate

   assign hit     = en_r[in_ch] && (pos_x || neg_x);
   assign hit_pol = pos_x ? POL_POS : POL_NEG;

   // R2
   cfg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> ($signed(cfg_pos) > $signed(cfg_neg)));
endmodule

// File: rtl/spk_capture.sv
module spk_capture
   import spk_pkg::*;
#(
   parameter int NUM_CH   = 64,
   parameter int SAMPLE_W = 10,
   parameter int PRE      = 4,
   parameter int WIN      = 16,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int CNT_W   = $clog2(WIN + 1),
   localparam int IDX_W   = $clog2(WIN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [CH_W-1:0]         in_ch,
   input  logic [SAMPLE_W-1:0]     in_sample,
   input  logic                    hit,
   input  spk_pol_e                hit_pol,
   output logic                    done,
   output logic [CH_W-1:0]         done_ch,
   output spk_pol_e                done_pol,
   output logic [WIN*SAMPLE_W-1:0] done_win
);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(WIN - 1);
   localparam logic [CNT_W-1:0] START = CNT_W'(PRE + 1);

   generate
      if (PRE < 1 || WIN <= PRE + 1) begin : g_bad_window
         $error("spk_capture: need 1 <= PRE and PRE + 1 < WIN");
      end
   endgenerate

   logic [SAMPLE_W-1:0] hist [NUM_CH][PRE];
   logic [SAMPLE_W-1:0] win  [NUM_CH][WIN-1];
   logic [CNT_W-1:0]    cnt  [NUM_CH];
   logic [NUM_CH-1:0]   act;
   spk_pol_e            pol  [NUM_CH];
   logic                cur_act;
   logic [CNT_W-1:0]    cur_cnt;

   assign cur_act  = act[in_ch];
   assign cur_cnt  = cnt[in_ch];
   assign done     = in_valid && cur_act && (cur_cnt == LAST);
   assign done_ch  = in_ch;
   assign done_pol = pol[in_ch];

   always_comb begin
      for (int i = 0; i < WIN - 1; i++)
         done_win[i*SAMPLE_W +: SAMPLE_W] = win[in_ch][i];
      done_win[(WIN-1)*SAMPLE_W +: SAMPLE_W] = in_sample;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NUM_CH; c++) begin
            for (int i = 0; i < PRE; i++) hist[c][i] <= '0;
            for (int i = 0; i < WIN - 1; i++) win[c][i] <= '0;
            cnt[c] <= '0;
            pol[c] <= POL_NEG;
         end
         act <= '0;
      end else if (in_valid) begin
         for (int i = 0; i < PRE - 1; i++) hist[in_ch][i] <= hist[in_ch][i+1];
         hist[in_ch][PRE-1] <= in_sample;
         if (cur_act) begin
            if (done) begin
               act[in_ch] <= 1'b0;
               cnt[in_ch] <= '0;
            end else begin
               win[in_ch][cur_cnt[IDX_W-1:0]] <= in_sample;
               cnt[in_ch] <= cur_cnt + 1'b1;
            end
         end else if (hit) begin
            for (int i = 0; i < PRE; i++) win[in_ch][i] <= hist[in_ch][i];
            win[in_ch][PRE] <= in_sample;
            cnt[in_ch] <= START;
            act[in_ch] <= 1'b1;
            pol[in_ch] <= hit_pol;
         end
      end
   end

   // R5 R10
   act_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(act) <= $past($countones(act)) + 1));
endmodule

// File: rtl/spk_evq.sv
module spk_evq
   import spk_pkg::*;
#(
   parameter int SAMPLE_W = 10,
   parameter int CH_W     = 6,
   parameter int WIN      = 16,
   parameter int DEPTH    = 2,
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int BEAT_W  = $clog2(WIN + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic [CH_W-1:0]         push_ch,
   input  spk_pol_e                push_pol,
   input  logic [WIN*SAMPLE_W-1:0] push_win,
   input  logic                    out_ready,
   output logic                    out_valid,
   output logic [SAMPLE_W-1:0]     out_data,
   output logic                    out_first,
   output logic                    out_last,
   output logic                    ovf
);
   localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(WIN);
   localparam logic [CNT_W-1:0]  FULL     = CNT_W'(DEPTH);

   generate
      if (CH_W > SAMPLE_W - 1) begin : g_bad_hdr
         $error("spk_evq: channel field overlaps the polarity bit");
      end
   endgenerate

   logic [WIN*SAMPLE_W-1:0] mem_win [DEPTH];
   logic [CH_W-1:0]         mem_ch  [DEPTH];
   spk_pol_e                mem_pol [DEPTH];
   logic [PTR_W-1:0]        wr_ptr, rd_ptr;
   logic [CNT_W-1:0]        count;
   logic [BEAT_W-1:0]       beat;
   logic                    xfer, pop, accept;
   logic [SAMPLE_W-1:0]     hdr, samp;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign out_valid = (count != '0);
   assign out_first = out_valid && (beat == '0);
   assign out_last  = out_valid && (beat == BEAT_END);
   assign xfer      = out_valid && out_ready;
   assign pop       = xfer && (beat == BEAT_END);
   assign accept    = push && ((count != FULL) || pop);

   always_comb begin
      hdr = '0;
      hdr[CH_W-1:0]   = mem_ch[rd_ptr];
      hdr[SAMPLE_W-1] = mem_pol[rd_ptr];
      samp = '0;
      for (int i = 0; i < WIN; i++)
         if (beat == BEAT_W'(i + 1)) samp = mem_win[rd_ptr][i*SAMPLE_W +: SAMPLE_W];
   end
   assign out_data = (beat == '0) ? hdr : samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) begin
            mem_win[d] <= '0;
            mem_ch[d]  <= '0;
            mem_pol[d] <= POL_NEG;
         end
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         beat   <= '0;
         ovf    <= 1'b0;
      end else begin
         if (accept) begin
            mem_win[wr_ptr] <= push_win;
            mem_ch[wr_ptr]  <= push_ch;
            mem_pol[wr_ptr] <= push_pol;
            wr_ptr          <= ptr_next(wr_ptr);
         end
         if (push && !accept) ovf <= 1'b1;
         if (xfer) beat <= pop ? '0 : beat + 1'b1;
         if (pop) rd_ptr <= ptr_next(rd_ptr);
         count <= count + CNT_W'(accept) - CNT_W'(pop);
      end
   end

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R9
   depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL);
   // R7
   frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && out_last) |=> (!out_valid || out_first));
endmodule

// File: rtl/spike_event_detector.sv
module spike_event_detector
   import spk_pkg::*;
#(
   parameter int NUM_CH    = 64,
   parameter int SAMPLE_W  = 10,
   parameter int PRE       = 4,
   parameter int WIN       = 16,
   parameter int EVQ_DEPTH = 2,
   parameter bit INCLUSIVE = 1'b0,
   localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [CH_W-1:0]     in_ch,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic                cfg_we,
   input  logic [CH_W-1:0]     cfg_ch,
   input  logic [SAMPLE_W-1:0] cfg_pos,
   input  logic [SAMPLE_W-1:0] cfg_neg,
   input  logic                cfg_en,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [SAMPLE_W-1:0] out_data,
   output logic                out_first,
   output logic                out_last,
   output logic                ovf
);
   logic                    hit, done;
   spk_pol_e                hit_pol, done_pol;
   logic [CH_W-1:0]         done_ch;
   logic [WIN*SAMPLE_W-1:0] done_win;

   spk_thresh_cfg #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .INCLUSIVE(INCLUSIVE)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_pos(cfg_pos), .cfg_neg(cfg_neg), .cfg_en(cfg_en),
      .in_ch(in_ch), .in_sample(in_sample),
      .hit(hit), .hit_pol(hit_pol)
   );

   spk_capture #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .PRE(PRE), .WIN(WIN)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ch(in_ch), .in_sample(in_sample),
      .hit(hit), .hit_pol(hit_pol),
      .done(done), .done_ch(done_ch), .done_pol(done_pol), .done_win(done_win)
   );

   spk_evq #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W), .WIN(WIN), .DEPTH(EVQ_DEPTH)) u_evq (
      .clk(clk), .rst_n(rst_n),
      .push(done), .push_ch(done_ch), .push_pol(done_pol), .push_win(done_win),
      .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
      .out_last(out_last), .ovf(ovf)
   );
endmodule

// File: tb/sim_spike_event_detector.sv
module sim_spike_event_detector;
   localparam int NC  = 8;
   localparam int DEP = 2;
   localparam int CW  = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [CW-1:0]  in_ch = '0;
   logic [9:0]     in_sample = '0;
   logic           cfg_we = 1'b0;
   logic [CW-1:0]  cfg_ch = '0;
   logic [9:0]     cfg_pos = '0, cfg_neg = '0;
   logic           cfg_en = 1'b0;
   logic           out_valid, out_ready, out_first, out_last, ovf;
   logic [9:0]     out_data;

   always #4 clk = ~clk;

   spike_event_detector #(.NUM_CH(NC), .EVQ_DEPTH(DEP)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_sample(in_sample),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_pos(cfg_pos), .cfg_neg(cfg_neg), .cfg_en(cfg_en),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_first(out_first), .out_last(out_last), .ovf(ovf)
   );

   int checks = 0, failures = 0, hdr_seen = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard model built from the requirements
   logic signed [9:0] pos_m [NC], neg_m [NC];
   logic              en_m  [NC];
   logic signed [9:0] hm    [NC][4];
   logic signed [9:0] wm    [NC][16];
   int                cnt_m [NC];
   logic              act_m [NC], pol_m [NC];
   int                evc = 0;
   logic              ovf_m = 1'b0;
   logic [11:0]       exp_q [$];

   task automatic model_reset();
      for (int c = 0; c < NC; c++) begin
         pos_m[c] = 10'sd511; neg_m[c] = -10'sd512; en_m[c] = 1'b0;
         act_m[c] = 1'b0; cnt_m[c] = 0; pol_m[c] = 1'b0;
         for (int i = 0; i < 4; i++) hm[c][i] = '0;
      end
      evc = 0; ovf_m = 1'b0; exp_q.delete();
   endtask

   task automatic model_in(input int c, input logic signed [9:0] s);
      logic [9:0] hdr;
      if (act_m[c]) begin
         wm[c][cnt_m[c]] = s;
         cnt_m[c]++;
         if (cnt_m[c] == 16) begin
            act_m[c] = 1'b0;
            if (evc < DEP) begin
               evc++;
               hdr = '0; hdr[CW-1:0] = CW'(c); hdr[9] = pol_m[c];
               exp_q.push_back({1'b1, 1'b0, hdr});
               for (int i = 0; i < 16; i++) exp_q.push_back({1'b0, (i == 15), wm[c][i]});
            end else ovf_m = 1'b1;
         end
      end else if (en_m[c] && (s > pos_m[c] || s < neg_m[c])) begin
         for (int i = 0; i < 4; i++) wm[c][i] = hm[c][i];
         wm[c][4] = s; cnt_m[c] = 5; act_m[c] = 1'b1; pol_m[c] = (s > pos_m[c]);
      end
      for (int i = 0; i < 3; i++) hm[c][i] = hm[c][i+1];
      hm[c][3] = s;
   endtask

   always @(negedge clk) begin
      if (!rst_n) model_reset();
      else begin
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 R6 unexpected word", int'(out_data), -1);
            else begin
               logic [11:0] e;
               e = exp_q.pop_front();
               // R4 R7 word contents and framing
               chk({out_first, out_last, out_data} == e, "R4 R7 packet word",
                   int'({out_first, out_last, out_data}), int'(e));
            end
            if (out_first) hdr_seen++;
            if (out_last) evc--;
         end
         if (in_valid) model_in(int'(in_ch), in_sample);
         if (cfg_we) begin
            pos_m[cfg_ch] = cfg_pos; neg_m[cfg_ch] = cfg_neg; en_m[cfg_ch] = cfg_en;
         end
      end
   end

   task automatic send(input int c, input logic [9:0] s);
      @(posedge clk); #1;
      cfg_we = 1'b0; in_valid = 1'b1; in_ch = CW'(c); in_sample = s;
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; in_valid = 1'b0; cfg_we = 1'b0;
      end
   endtask
   task automatic cfg(input int c, input logic [9:0] p, input logic [9:0] n, input logic e);
      @(posedge clk); #1;
      in_valid = 1'b0; cfg_we = 1'b1; cfg_ch = CW'(c); cfg_pos = p; cfg_neg = n; cfg_en = e;
   endtask
   task automatic drain();
      @(posedge clk); #1; in_valid = 1'b0; cfg_we = 1'b0; out_ready = 1'b1;
      while (exp_q.size() != 0 || out_valid) @(posedge clk);
      #1;
   endtask
   task automatic setup_all();
      for (int c = 0; c < NC; c++) cfg(c, 10'sd100, -10'sd100, (c != 5));
      cfg(3, 10'sd50, -10'sd20, 1'b1);
      idle(1);
   endtask

   // {channel, sample}
   localparam logic [12:0] VEC [14] = '{
      {3'd0, 10'(10)},  {3'd0, 10'(-5)},  {3'd1, 10'(200)}, {3'd0, 10'(100)},
      {3'd0, 10'(101)}, {3'd3, 10'(-21)}, {3'd2, 10'(-100)},{3'd2, 10'(-101)},
      {3'd5, 10'(400)}, {3'd6, 10'(7)},   {3'd4, 10'(-300)},{3'd3, 10'(60)},
      {3'd7, 10'(99)},  {3'd6, 10'(101)}
   };

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int base;
      logic [9:0] d0;
      out_ready = 1'b1;
      model_reset();
      idle(3);
      // R11 reset state
      chk(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
      chk(ovf == 1'b0, "R11 ovf after reset", int'(ovf), 0);
      rst_n = 1'b1;
      setup_all();

      // R1 R2 R3 R4 R10: table walk, then complete each channel in turn
      for (int v = 0; v < 14; v++) send(int'(VEC[v][12:10]), VEC[v][9:0]);
      for (int c = 0; c < NC; c++) begin
         for (int i = 0; i < 15; i++) send(c, 10'(i));
         drain();
      end
      // R3 R6: six channels triggered, channel 5 disabled, equal values ignored
      chk(hdr_seen == 6, "R3 R6 event count from table", hdr_seen, 6);

      // R5 refractory
      base = hdr_seen;
      send(2, 10'(200)); send(2, 10'(300)); send(2, 10'(-300));
      for (int i = 0; i < 9; i++) send(2, 10'(0));
      send(2, 10'(0));
      drain();
      chk(hdr_seen == base + 1, "R5 one event despite repeated crossings", hdr_seen, base + 1);

      // R6 disabled channel
      base = hdr_seen;
      send(5, 10'(500)); send(5, 10'(-500));
      idle(20);
      chk(out_valid == 1'b0, "R6 disabled channel out_valid", int'(out_valid), 0);
      chk(hdr_seen == base, "R6 disabled channel events", hdr_seen, base);

      // R8 back-pressure hold
      @(posedge clk); #1 out_ready = 1'b0;
      send(7, 10'(150));
      for (int i = 0; i < 11; i++) send(7, 10'(1));
      idle(3);
      @(negedge clk); d0 = out_data;
      idle(5);
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid held under stall", int'(out_valid), 1);
      chk(out_first == 1'b1, "R8 header held under stall", int'(out_first), 1);
      chk(out_data == d0, "R8 data stable under stall", int'(out_data), int'(d0));
      chk(out_data == 10'h207, "R7 header channel 7 positive", int'(out_data), 'h207);
      drain();

      // R9 overflow: three windows finish with a stalled sink
      base = hdr_seen;
      @(posedge clk); #1 out_ready = 1'b0;
      send(0, 10'(200)); send(1, -10'sd200); send(2, 10'(250));
      for (int r = 0; r < 11; r++) for (int c = 0; c < 3; c++) send(c, 10'(r));
      idle(2);
      chk(ovf == 1'b1, "R9 ovf set on drop", int'(ovf), 1);
      chk(ovf == ovf_m, "R9 ovf matches model", int'(ovf), int'(ovf_m));
      drain();
      chk(hdr_seen == base + DEP, "R9 queued events delivered", hdr_seen, base + DEP);
      idle(5);
      chk(ovf == 1'b1, "R9 ovf sticky", int'(ovf), 1);

      // R11 reset mid capture
      send(4, 10'(300)); send(4, 10'(1)); send(4, 10'(2));
      @(posedge clk); #1 in_valid = 1'b0; rst_n = 1'b0;
      idle(2);
      chk(ovf == 1'b0, "R11 ovf cleared", int'(ovf), 0);
      chk(out_valid == 1'b0, "R11 queue cleared", int'(out_valid), 0);
      rst_n = 1'b1;
      base = hdr_seen;
      // R2: reset left channel 4 disabled, so a crossing does nothing
      send(4, 10'(500));
      idle(3);
      cfg(4, 10'sd100, -10'sd100, 1'b1);
      for (int i = 0; i < 13; i++) send(4, 10'(i));
      idle(20);
      chk(hdr_seen == base, "R11 R2 no event from cleared capture", hdr_seen, base);
      send(4, -10'sd150);
      for (int i = 0; i < 11; i++) send(4, 10'(20 + i));
      drain();
      chk(hdr_seen == base + 1, "R4 window after reset", hdr_seen, base + 1);
      chk(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule